// File: doc/BRIEF.md
# Falling-Edge History Gate

This block drives a single output `x_o` from two single-bit inputs, `a_i` and `b_i`, using one bit of stored history. The history bit records whether `b_i` has fallen while `a_i` was high since the last time both inputs were high together. While the bit is clear the output is held high. While it is set the output follows `b_i`. Whenever `a_i` and `b_i` are high at the same time the bit is cleared.

The logic runs on a fast system clock that samples both inputs. It finds the falling edge of `b_i` by comparing each sample with a registered copy of the previous one. The output is formed combinationally from the sampled `b_i` and the next value of the history bit. As a result, with no synchronizer fitted, an edge on `b_i` reaches `x_o` in the same cycle and no register lies in that path.

The parameter `SYNC_STAGES` places a flop chain of that length in front of both inputs, for inputs that are asynchronous to the clock. The block assumes that only one of the two inputs changes between consecutive samples.

Top module: `hist_gate`

## Requirements
- R1: While `rst_i` is high, `x_o` is 1. The history bit and the registered previous-B value are both cleared, so no falling edge is seen in the first cycle after reset.
- R2: In any cycle where sampled A and sampled B are both 1, `x_o` is 1 and the history bit is 0 from the next cycle on.
- R3: When sampled B goes from 1 to 0 while sampled A is 1, `x_o` is 0 in that same sampled cycle and the history bit is 1 from the next cycle on.
- R4: When sampled B goes from 1 to 0 while sampled A is 0, the history bit keeps its value, so `x_o` stays 1 if the bit was clear.
- R5: Once the history bit is set, it stays set through any number of B pulses until A and B are both 1 in the same cycle. During that time `x_o` equals sampled B.
- R6: A change on A while B is steady never changes `x_o`.
- R7: `x_o` equals (sampled B) OR NOT(history bit after this cycle's update). With `SYNC_STAGES` = 0, a change on `b_i` reaches `x_o` with no clock cycle of latency.
- R8: With `SYNC_STAGES` = N > 0, both inputs are delayed by exactly N clock cycles before use. The synchronizer flops reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| a_i | input | 1 | Qualifying input A |
| b_i | input | 1 | Gated input B |
| x_o | output | 1 | Output: B, or forced high while history is clear |

## Verification
The bench replays both waveform shapes, including repeated B pulses while history is set. A design whose set condition was too loose would drop the output on later pulses after A had gone low. A design that did not hold history would let the output return high after the first pulse. A toggles while B is low, to catch a design that re-arms on A alone. B falls with A low right after a clear, to catch a design that sets history without checking A. A one-cycle output lag on the B fall would show as a mismatch on the very cycle B drops. The same stimulus also drives a two-stage synchronized copy against a delayed reference, so a wrong delay or a wrong synchronizer reset value is caught.

// File: rtl/hist_gate_pkg.sv
package hist_gate_pkg;
    typedef struct packed {
        logic prev_b;
        logic hist;
    } hg_state_t;
    localparam hg_state_t HG_RESET = '{prev_b: 1'b0, hist: 1'b0};
endpackage

// File: rtl/hist_gate_sync.sv
module hist_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_i,
    input  logic b_i,
    output logic a_o,
    output logic b_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] a_d, a_q, b_d, b_q;

    always_comb begin
        a_d[0] = a_i;
        b_d[0] = b_i;
        for (int i = 1; i < STAGES; i++) begin
            a_d[i] = a_q[i-1];
            b_d[i] = b_q[i-1];
        end
        if (rst_i) begin
            a_d = '0;
            b_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        a_q <= a_d;
        b_q <= b_d;
    end

    assign a_o = a_q[LAST];
    assign b_o = b_q[LAST];
endmodule

// File: rtl/hist_gate_core.sv
module hist_gate_core
    import hist_gate_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_s,
    input  logic b_s,
    output logic x_o,
    output logic hist_o,
    output logic prev_b_o
);
    hg_state_t st_d, st_q;
    logic fall_b;
    logic both_hi;

    always_comb begin
        st_d    = st_q;
        fall_b  = st_q.prev_b & ~b_s;
        both_hi = a_s & b_s;
        st_d.prev_b = b_s;
        if (both_hi) begin
            st_d.hist = 1'b0;
        end else if (fall_b) begin
            st_d.hist = st_q.hist | a_s;
        end
        if (rst_i) begin
            st_d = HG_RESET;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign x_o      = b_s | ~st_d.hist;
    assign hist_o   = st_q.hist;
    assign prev_b_o = st_q.prev_b;
endmodule

// File: rtl/hist_gate.sv
module hist_gate #(
    parameter int SYNC_STAGES = 0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic a_i,
    input  logic b_i,
    output logic x_o
);
    logic a_smp, b_smp;
    logic hist_q, prevb_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            hist_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk_i (clk_i),
                .rst_i (rst_i),
                .a_i   (a_i),
                .b_i   (b_i),
                .a_o   (a_smp),
                .b_o   (b_smp)
            );
        end else begin : g_direct
            assign a_smp = a_i;
            assign b_smp = b_i;
        end
    endgenerate

    hist_gate_core u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .a_s      (a_smp),
        .b_s      (b_smp),
        .x_o      (x_o),
        .hist_o   (hist_q),
        .prev_b_o (prevb_q)
    );
endmodule

// File: rtl/hist_gate_chk.sv
module hist_gate_chk (
    input logic clk,
    input logic rst,
    input logic a_s,
    input logic b_s,
    input logic prev_b,
    input logic hist,
    input logic x
);
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (!hist && !prev_b));
    a_r1_reset_out_high: assert property (@(posedge clk) rst |-> x);
    a_r2_clear: assert property (@(posedge clk) disable iff (rst)
        (a_s && b_s) |=> !hist);
    a_r3_set: assert property (@(posedge clk) disable iff (rst)
        (prev_b && !b_s && a_s) |=> hist);
    a_r3_low_now: assert property (@(posedge clk) disable iff (rst)
        (prev_b && !b_s && a_s) |-> !x);
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!hist && !(prev_b && !b_s && a_s)) |=> !hist);
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        (hist && !(a_s && b_s)) |=> hist);
    a_r7_b_high_out_high: assert property (@(posedge clk) disable iff (rst)
        b_s |-> x);
    a_r7_tracks_when_set: assert property (@(posedge clk) disable iff (rst)
        (hist && !b_s) |-> !x);
endmodule

bind hist_gate hist_gate_chk u_chk (
    .clk    (clk_i),
    .rst    (rst_i),
    .a_s    (a_smp),
    .b_s    (b_smp),
    .prev_b (prevb_q),
    .hist   (hist_q),
    .x      (x_o)
);

// File: tb/hist_gate_tb.sv
`timescale 1ns/1ps
module hist_gate_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a = 1'b1;
    logic b = 1'b1;
    logic x, x_sync;
    int n_checks = 0;
    int n_fail = 0;

    // reference state for direct instance [0] and synchronized instance [1]
    bit m_s[2];
    bit m_pb[2];
    bit d1a, d1b, d2a, d2b;

    always #5 clk = ~clk;

    hist_gate #(.SYNC_STAGES(0)) u_dut (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .x_o(x)
    );
    hist_gate #(.SYNC_STAGES(2)) u_dut_sync (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b), .x_o(x_sync)
    );

    function automatic string tag_for(bit r, bit aa, bit bb, bit pb, bit s);
        if (r) return "R1 reset";
        if (aa && bb) return "R2 clear";
        if (pb && !bb && aa) return "R3 set/zero-latency R7";
        if (pb && !bb) return "R4 fall with A low";
        if (s && pb == bb) return "R5/R6 history held";
        return "R6/R7 output";
    endfunction

    // one reference cycle: returns expected X, updates stored history
    function automatic bit ref_step(int k, bit r, bit aa, bit bb, output string tg);
        bit fell, lo, e;
        tg = tag_for(r, aa, bb, m_pb[k], m_s[k]);
        if (k == 1) tg = {"R8 sync: ", tg};
        if (r) begin
            m_s[k] = 0; m_pb[k] = 0;
            return 1'b1;
        end
        fell = m_pb[k] && !bb;
        lo   = !bb && (m_s[k] || (fell && aa));
        e    = !lo;
        if (aa && bb) m_s[k] = 0;
        else if (!bb) m_s[k] = lo;
        m_pb[k] = bb;
        return e;
    endfunction

    task automatic check(bit got, bit exp, string tg);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: x=%b expected %b", tg, $time, got, exp);
        end
    endtask

    task automatic step(bit r, bit aa, bit bb);
        bit e0, e1;
        string t0, t1;
        @(negedge clk);
        rst = r; a = aa; b = bb;
        #2;
        e0 = ref_step(0, r, aa, bb, t0);
        e1 = ref_step(1, r, d2a, d2b, t1);
        check(x, e0, t0);
        check(x_sync, e1, t1);
        if (r) begin
            d1a = 0; d1b = 0; d2a = 0; d2b = 0;
        end else begin
            d2a = d1a; d2b = d1b; d1a = aa; d1b = bb;
        end
    endtask

    task automatic hold(bit aa, bit bb, int n);
        for (int i = 0; i < n; i++) step(1'b0, aa, bb);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        bit ca, cb;
        // R1: reset with inputs in a state that would otherwise set history
        step(1, 1, 1);
        step(1, 1, 0);
        step(1, 1, 0);
        hold(1, 1, 4);
        // first waveform: B pulse with A high, then A activity
        hold(1, 0, 3);          // R3: X drops with B at once
        hold(1, 1, 3);          // R2: clear
        hold(0, 1, 3);          // R6
        hold(0, 0, 3);          // R4: fall with A low, X stays high
        hold(1, 0, 3);          // R6: A rises, B low
        hold(1, 1, 3);
        // second waveform: repeated B pulses while history set
        hold(1, 0, 3);          // R3
        hold(0, 0, 2);          // R6 A toggles while B low
        hold(1, 0, 2);
        hold(0, 0, 2);
        hold(0, 1, 3);          // R5 tracks B
        hold(0, 0, 3);
        hold(0, 1, 2);
        hold(0, 0, 2);
        hold(0, 1, 2);
        hold(1, 1, 3);          // R2 clear
        hold(0, 1, 2);
        hold(0, 0, 3);          // R4 X high
        hold(0, 1, 2);
        // mid-run reset while history set
        hold(1, 1, 2);
        hold(1, 0, 2);
        step(1, 1, 0);
        hold(1, 0, 3);          // R1 no false fall after reset
        hold(1, 1, 2);
        // random walk: one input changes per step
        ca = 1; cb = 1;
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 0) ca = ~ca;
            else cb = ~cb;
            hold(ca, cb, $urandom_range(1, 3));
        end
        hold(1, 1, 4);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule